// File: doc/BRIEF.md
# 8b/10b Line Encoder Bank with Disparity Override

This block turns bytes into 10-bit DC-balanced code groups for a set of parallel lanes. Each lane takes one byte plus a flag that marks it as a control character or a data character. It splits the byte into a 5-bit and a 3-bit part and encodes them through a 5b/6b and a 3b/4b stage. It tracks the running disparity of the lane and picks the code from the negative or the positive column to keep the line balanced.

A per-lane pair of override inputs can replace the tracked disparity for one character with a value chosen by the user. The disparity that follows that character is then computed from the forced value. A control byte that is not a legal control character is replaced by the comma character, and a flag marks the substitution. Each lane has its own strobe. Its code, disparity and flag are registered one clock after the strobe.

Top module: `cg_encoder_bank`

## Requirements
- R1: While reset is asserted, and in the cycles after it is released until a lane's first strobe, that lane's code output is 10'h000, its disparity output is 0 (negative) and its error flag is 0. The first character after reset is encoded from the negative column.
- R2: Code bit layout: code[9:4] carries the 6-bit group abcdei with a in bit 9. code[3:0] carries fghj with f in bit 3. Input byte bits [4:0] form the 5b part and bits [7:5] form the 3b part. Data characters follow the standard 8b/10b tables (for example, D.0.0 from the negative column is 10'h274).
- R3: The disparity output (1 = positive) shows the running disparity after the last encoded character. It flips exactly when the emitted code group has a number of ones other than five.
- R4: The column is chosen from the running disparity in effect. The same character gives complementary unbalanced sub-blocks in the two columns (K28.5 is 10'h0FA from negative, 10'h305 from positive).
- R5: For data characters with the 3b part equal to 7, the alternate 4-bit code is used for D.17/D.18/D.20 when the disparity after the 6-bit part is negative, and for D.11/D.13/D.14 when it is positive (D.17.7 from negative is 10'h237, D.11.7 from positive is 10'h348). In all other cases the primary code is used.
- R6: The legal control characters are K28.0 through K28.7, K23.7, K27.7, K29.7 and K30.7. All of them use the alternate 4-bit code for the 3b part 7 (K23.7 from positive is 10'h057).
- R7: A byte with the control flag set that is not a legal control character produces the K28.5 code for the disparity in effect. The error flag goes to 1 in the same cycle as that code. A legal character clears the flag.
- R8: When a lane's force bit is 1 on a strobe, that character uses the lane's value bit as its starting disparity instead of the tracked one. The following disparity is computed from that forced value.
- R9: While a lane's strobe is 0, its code, disparity and error flag hold their values. Its byte, flag and override inputs have no effect.
- R10: Lanes are independent. Strobing or forcing one lane leaves the outputs of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lane_en | input | NUM_LANES | Per-lane character strobe |
| lane_byte | input | 8*NUM_LANES | Bytes, lane i at bits [8i+7:8i] |
| lane_is_ctrl | input | NUM_LANES | 1 = byte is a control character |
| rd_force | input | NUM_LANES | 1 = override the starting disparity for this character |
| rd_force_val | input | NUM_LANES | Forced starting disparity, 1 = positive |
| code_out | output | 10*NUM_LANES | Code groups, lane i at bits [10i+9:10i] |
| rd_out | output | NUM_LANES | Running disparity after the last character, 1 = positive |
| ctrl_err | output | NUM_LANES | Illegal control byte was replaced by K28.5 |

## Verification
Two functions can act in the same cycle: a disparity override and the substitution of an illegal control byte. Both act on the same character and must agree on which column the comma comes from. The bench strobes an illegal control byte with the force bit set and a forced value opposite to the tracked disparity. It then expects the positive-column K28.5, the error flag, and a disparity that follows from the forced value and not from the tracked one. The bench also strobes one lane while another sits idle, and checks that the idle lane's state is untouched.

// File: rtl/cg_enc_pkg.sv
package cg_enc_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 10;
  localparam int X_W    = 5;
  localparam int Y_W    = 3;
  localparam logic [BYTE_W-1:0] COMMA_BYTE = 8'hBC;

  function automatic logic legal_ctrl(input logic [BYTE_W-1:0] b);
    logic [X_W-1:0] x;
    logic [Y_W-1:0] y;
    x = b[X_W-1:0];
    y = b[BYTE_W-1:X_W];
    legal_ctrl = (x == 5'd28) ||
                 ((y == 3'd7) && ((x == 5'd23) || (x == 5'd27) ||
                                  (x == 5'd29) || (x == 5'd30)));
  endfunction
endpackage

// File: rtl/cg_enc_6b.sv
module cg_enc_6b
  import cg_enc_pkg::*;
(
  input  logic [X_W-1:0] x_in,
  input  logic           k28_in,
  input  logic           rd_in,
  output logic [5:0]     code6,
  output logic           rd_mid
);
  logic [5:0] neg_col;
  logic       unbal;
  logic       flip_col;

  always_comb begin
    unique case (x_in)
      5'd0:  neg_col = 6'b100111;
      5'd1:  neg_col = 6'b011101;
      5'd2:  neg_col = 6'b101101;
      5'd3:  neg_col = 6'b110001;
      5'd4:  neg_col = 6'b110101;
      5'd5:  neg_col = 6'b101001;
      5'd6:  neg_col = 6'b011001;
      5'd7:  neg_col = 6'b111000;
      5'd8:  neg_col = 6'b111001;
      5'd9:  neg_col = 6'b100101;
      5'd10: neg_col = 6'b010101;
      5'd11: neg_col = 6'b110100;
      5'd12: neg_col = 6'b001101;
      5'd13: neg_col = 6'b101100;
      5'd14: neg_col = 6'b011100;
      5'd15: neg_col = 6'b010111;
      5'd16: neg_col = 6'b011011;
      5'd17: neg_col = 6'b100011;
      5'd18: neg_col = 6'b010011;
      5'd19: neg_col = 6'b110010;
      5'd20: neg_col = 6'b001011;
      5'd21: neg_col = 6'b101010;
      5'd22: neg_col = 6'b011010;
      5'd23: neg_col = 6'b111010;
      5'd24: neg_col = 6'b110011;
      5'd25: neg_col = 6'b100110;
      5'd26: neg_col = 6'b010110;
      5'd27: neg_col = 6'b110110;
      5'd28: neg_col = k28_in ? 6'b001111 : 6'b001110;
      5'd29: neg_col = 6'b101110;
      5'd30: neg_col = 6'b011110;
      default: neg_col = 6'b101011;
    endcase
  end

  always_comb begin
    unbal    = ($countones(neg_col) != 3);
    flip_col = rd_in && (unbal || (x_in == 5'd7));
    code6    = flip_col ? ~neg_col : neg_col;
    rd_mid   = rd_in ^ unbal;
  end
endmodule

// File: rtl/cg_enc_4b.sv
module cg_enc_4b
  import cg_enc_pkg::*;
(
  input  logic [Y_W-1:0] y_in,
  input  logic [X_W-1:0] x_in,
  input  logic           is_k,
  input  logic           rd_mid,
  output logic [3:0]     code4,
  output logic           rd_end
);
  logic       alt7;
  logic [3:0] neg_col;
  logic       unbal;
  logic       flip_col;

  always_comb begin
    alt7 = is_k ||
           (!rd_mid && ((x_in == 5'd17) || (x_in == 5'd18) || (x_in == 5'd20))) ||
           ( rd_mid && ((x_in == 5'd11) || (x_in == 5'd13) || (x_in == 5'd14)));
    if (is_k) begin
      unique case (y_in)
        3'd0: neg_col = 4'b1011;
        3'd1: neg_col = 4'b0110;
        3'd2: neg_col = 4'b1010;
        3'd3: neg_col = 4'b1100;
        3'd4: neg_col = 4'b1101;
        3'd5: neg_col = 4'b0101;
        3'd6: neg_col = 4'b1001;
        default: neg_col = 4'b0111;
      endcase
    end else begin
      unique case (y_in)
        3'd0: neg_col = 4'b1011;
        3'd1: neg_col = 4'b1001;
        3'd2: neg_col = 4'b0101;
        3'd3: neg_col = 4'b1100;
        3'd4: neg_col = 4'b1101;
        3'd5: neg_col = 4'b1010;
        3'd6: neg_col = 4'b0110;
        default: neg_col = alt7 ? 4'b0111 : 4'b1110;
      endcase
    end
  end

  always_comb begin
    unbal    = ($countones(neg_col) != 2);
    flip_col = rd_mid && (is_k || unbal || (y_in == 3'd3));
    code4    = flip_col ? ~neg_col : neg_col;
    rd_end   = rd_mid ^ unbal;
  end
endmodule

// File: rtl/cg_enc_lane.sv
module cg_enc_lane
  import cg_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              is_ctrl,
  input  logic              force_en,
  input  logic              force_val,
  output logic [CODE_W-1:0] code_q,
  output logic              rd_q,
  output logic              err_q
);
  logic              bad;
  logic [BYTE_W-1:0] eff_byte;
  logic              rd_start;
  logic              rd_mid;
  logic              rd_end;
  logic [5:0]        c6;
  logic [3:0]        c4;
  logic [CODE_W-1:0] code_d;
  logic              rd_d;
  logic              err_d;

  always_comb begin
    bad      = is_ctrl && !legal_ctrl(byte_in);
    eff_byte = bad ? COMMA_BYTE : byte_in;
    rd_start = force_en ? force_val : rd_q;
  end

  cg_enc_6b u_6b (
    .x_in   (eff_byte[X_W-1:0]),
    .k28_in (is_ctrl),
    .rd_in  (rd_start),
    .code6  (c6),
    .rd_mid (rd_mid)
  );

  cg_enc_4b u_4b (
    .y_in   (eff_byte[BYTE_W-1:X_W]),
    .x_in   (eff_byte[X_W-1:0]),
    .is_k   (is_ctrl),
    .rd_mid (rd_mid),
    .code4  (c4),
    .rd_end (rd_end)
  );

  always_comb begin
    code_d = code_q;
    rd_d   = rd_q;
    err_d  = err_q;
    if (en) begin
      code_d = {c6, c4};
      rd_d   = rd_end;
      err_d  = bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      rd_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      rd_q   <= rd_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/cg_encoder_bank.sv
module cg_encoder_bank
  import cg_enc_pkg::*;
#(
  parameter int NUM_LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LANES-1:0]        lane_en,
  input  logic [BYTE_W*NUM_LANES-1:0] lane_byte,
  input  logic [NUM_LANES-1:0]        lane_is_ctrl,
  input  logic [NUM_LANES-1:0]        rd_force,
  input  logic [NUM_LANES-1:0]        rd_force_val,
  output logic [CODE_W*NUM_LANES-1:0] code_out,
  output logic [NUM_LANES-1:0]        rd_out,
  output logic [NUM_LANES-1:0]        ctrl_err
);
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    cg_enc_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .en        (lane_en[i]),
      .byte_in   (lane_byte[BYTE_W*i +: BYTE_W]),
      .is_ctrl   (lane_is_ctrl[i]),
      .force_en  (rd_force[i]),
      .force_val (rd_force_val[i]),
      .code_q    (code_out[CODE_W*i +: CODE_W]),
      .rd_q      (rd_out[i]),
      .err_q     (ctrl_err[i])
    );
  end
endmodule

// File: rtl/cg_encoder_bank_chk.sv
module cg_encoder_bank_chk
  import cg_enc_pkg::*;
#(
  parameter int NUM_LANES = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_LANES-1:0]        lane_en,
  input logic [BYTE_W*NUM_LANES-1:0] lane_byte,
  input logic [NUM_LANES-1:0]        lane_is_ctrl,
  input logic [NUM_LANES-1:0]        rd_force,
  input logic [NUM_LANES-1:0]        rd_force_val,
  input logic [CODE_W*NUM_LANES-1:0] code_out,
  input logic [NUM_LANES-1:0]        rd_out,
  input logic [NUM_LANES-1:0]        ctrl_err
);
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_chk
    // R9: idle lane holds its state
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_en[i] |=> ($stable(code_out[CODE_W*i +: CODE_W]) &&
                       $stable(rd_out[i]) && $stable(ctrl_err[i])));

    // R3, R8: disparity follows the starting value and the code balance
    p_rd_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lane_en[i] |=> (rd_out[i] ==
        (($past(rd_force[i]) ? $past(rd_force_val[i]) : $past(rd_out[i])) ^
         ($countones(code_out[CODE_W*i +: CODE_W]) != 5))));

    // R2: every emitted group carries four to six ones
    p_balance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lane_en[i] |=> (($countones(code_out[CODE_W*i +: CODE_W]) >= 4) &&
                      ($countones(code_out[CODE_W*i +: CODE_W]) <= 6)));

    // R7: a raised error flag comes with a comma code
    p_err_comma_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_err[i] |-> ((code_out[CODE_W*i +: CODE_W] == 10'h0FA) ||
                       (code_out[CODE_W*i +: CODE_W] == 10'h305)));

    // R6: a legal comma request never raises the error flag
    p_legal_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_en[i] && lane_is_ctrl[i] && (lane_byte[BYTE_W*i +: BYTE_W] == 8'hBC))
        |=> !ctrl_err[i]);
  end
endmodule

bind cg_encoder_bank cg_encoder_bank_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lane_en      (lane_en),
  .lane_byte    (lane_byte),
  .lane_is_ctrl (lane_is_ctrl),
  .rd_force     (rd_force),
  .rd_force_val (rd_force_val),
  .code_out     (code_out),
  .rd_out       (rd_out),
  .ctrl_err     (ctrl_err)
);

// File: tb/cg_encoder_bank_tb.sv
module cg_encoder_bank_tb;
  localparam int NL = 2;

  logic          clk;
  logic          rst_n;
  logic [NL-1:0] lane_en;
  logic [8*NL-1:0] lane_byte;
  logic [NL-1:0] lane_is_ctrl;
  logic [NL-1:0] rd_force;
  logic [NL-1:0] rd_force_val;
  logic [10*NL-1:0] code_out;
  logic [NL-1:0] rd_out;
  logic [NL-1:0] ctrl_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cg_encoder_bank #(.NUM_LANES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .lane_byte(lane_byte),
    .lane_is_ctrl(lane_is_ctrl), .rd_force(rd_force), .rd_force_val(rd_force_val),
    .code_out(code_out), .rd_out(rd_out), .ctrl_err(ctrl_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {byte, ctrl, force, val, code, rd_after, err}
  localparam int NV = 16;
  localparam logic [22:0] VEC [NV] = '{
    {8'h00, 1'b0, 1'b0, 1'b0, 10'h274, 1'b0, 1'b0}, // R1 R2 first from negative
    {8'hBC, 1'b1, 1'b0, 1'b0, 10'h0FA, 1'b1, 1'b0}, // R4 R6 K28.5 negative
    {8'hBC, 1'b1, 1'b0, 1'b0, 10'h305, 1'b0, 1'b0}, // R4 K28.5 positive
    {8'hB5, 1'b0, 1'b0, 1'b0, 10'h2AA, 1'b0, 1'b0}, // R2 D.21.5
    {8'hF1, 1'b0, 1'b0, 1'b0, 10'h237, 1'b1, 1'b0}, // R5 D.17.7 alt
    {8'hEB, 1'b0, 1'b0, 1'b0, 10'h348, 1'b0, 1'b0}, // R5 D.11.7 alt
    {8'h63, 1'b0, 1'b0, 1'b0, 10'h31C, 1'b0, 1'b0}, // R3 D.3.3 balanced
    {8'h00, 1'b0, 1'b1, 1'b1, 10'h18B, 1'b1, 1'b0}, // R8 forced positive
    {8'h27, 1'b0, 1'b1, 1'b0, 10'h389, 1'b0, 1'b0}, // R8 forced negative
    {8'h00, 1'b1, 1'b0, 1'b0, 10'h0FA, 1'b1, 1'b1}, // R7 illegal control
    {8'hF7, 1'b1, 1'b0, 1'b0, 10'h057, 1'b1, 1'b0}, // R6 K23.7
    {8'hFC, 1'b1, 1'b0, 1'b0, 10'h307, 1'b1, 1'b0}, // R6 K28.7
    {8'h07, 1'b0, 1'b0, 1'b0, 10'h074, 1'b0, 1'b0}, // R4 D.7.0 positive
    {8'hFF, 1'b0, 1'b0, 1'b0, 10'h2B1, 1'b0, 1'b0}, // R5 D.31.7 primary
    {8'h1C, 1'b1, 1'b0, 1'b0, 10'h0F4, 1'b0, 1'b0}, // R6 K28.0
    {8'h01, 1'b1, 1'b1, 1'b1, 10'h305, 1'b0, 1'b1}  // R7 R8 force plus illegal
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input int ln, input logic en, input logic [7:0] b,
                       input logic k, input logic f, input logic v);
    lane_en[ln]          = en;
    lane_byte[8*ln +: 8] = b;
    lane_is_ctrl[ln]     = k;
    rd_force[ln]         = f;
    rd_force_val[ln]     = v;
  endtask

  function automatic logic [11:0] lane_state(input int ln);
    return {code_out[10*ln +: 10], rd_out[ln], ctrl_err[ln]};
  endfunction

  initial begin
    lane_en = '0; lane_byte = '0; lane_is_ctrl = '0; rd_force = '0; rd_force_val = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset lane0", lane_state(0), 12'h000);
    check("R1 reset lane1", lane_state(1), 12'h000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", lane_state(0), 12'h000);

    for (int i = 0; i < NV; i++) begin
      drive(0, 1'b1, VEC[i][22:15], VEC[i][14], VEC[i][13], VEC[i][12]);
      @(negedge clk);
      check($sformatf("vector %0d", i), lane_state(0), VEC[i][11:0]);
    end

    // R9: idle strobe, inputs wiggled
    drive(0, 1'b0, 8'hBC, 1'b1, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    check("R9 hold", lane_state(0), {10'h305, 1'b0, 1'b1});

    // R10: lane1 untouched so far, strobe it while lane0 idle
    check("R10 lane1 idle", lane_state(1), 12'h000);
    drive(1, 1'b1, 8'hBC, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    drive(1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R10 lane1 K28.5", lane_state(1), {10'h0FA, 1'b1, 1'b0});
    check("R10 lane0 unchanged", lane_state(0), {10'h305, 1'b0, 1'b1});

    // R1: mid-run reset returns to negative column
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset", lane_state(1), 12'h000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1, 1'b1, 8'hBC, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    drive(1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R1 first after reset", lane_state(1), {10'h0FA, 1'b1, 1'b0});
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule